// File: doc/BRIEF.md
# Link Latency Measurement Counter

This block measures, in link clock cycles, how long a serial receive link takes to go from releasing its active-low SYNC request to delivering its first valid word of user data. SYNC and the receive-data-valid indication are registered on the link clock, and their edges are taken from those registered copies. A release of SYNC starts a counter. The first rising edge of valid stops it and latches the result. The result is held, with a done flag, until SYNC is released again.

Each reset of the link repeats the measurement. The smallest and largest completed results are kept across those resets in a statistics section. Only its own clear input wipes that section. A variation flag rises when the spread between the smallest and largest result exceeds one cycle, which is the most that word alignment can add.

The controller has four states. WAIT_REL waits for a release. COUNTING runs the counter. HELD presents a finished result. SATURATED presents an overflowed one. The transitions are:
- START: WAIT_REL, HELD or SATURATED go to COUNTING on a release.
- INSTANT: a release and a valid edge seen in the same cycle go straight to HELD with a result of 0.
- FINISH: COUNTING goes to HELD on a valid edge.
- ABORT: COUNTING goes to WAIT_REL when SYNC is reasserted.
- OVERFLOW: COUNTING goes to SATURATED when the counter is at its ceiling and no valid edge arrives.

Top module: `lnklat_meter`

## Requirements
- R1: While `rst_n` is low, `lat_done`, `lat_ovf` and `lat_count` are 0. While `stats_clr_n` is low, `stats_valid`, `lat_min`, `lat_max` and `lat_var` are 0.
- R2: A release is a `sync_n` sample of 1 at edge Es that follows a sample of 0 at the edge before it. A release clears `lat_done`, `lat_ovf` and `lat_count`, and counting starts.
- R3: Let Ev be the first edge after Es at which `data_vld` is sampled 1, following a 0 sample. At edge Ev+1, `lat_count` becomes Ev−Es and `lat_done` becomes 1.
- R4: If valid rises at the same edge Es as the release, the result is 0 and `lat_done` is set at Es+1.
- R5: Once `lat_done` is 1, further `data_vld` activity does not change `lat_count`, `lat_done` or the statistics. This lasts until the next release.
- R6: If `sync_n` is sampled 0 during counting, the measurement is abandoned. `lat_done` stays 0, the statistics do not change, and a valid edge that follows is ignored until the next release.
- R7: If the count reaches 2^CNT_W−1 with no valid edge, `lat_count` stays at that value and `lat_ovf` and `lat_done` are both 1. The statistics do not change.
- R8: A new release after a finished or overflowed result starts a fresh measurement without any reset.
- R9: The first completed result after a statistics clear sets `lat_min` and `lat_max` to that result and sets `stats_valid`. Each later completed result lowers `lat_min` or raises `lat_max` as needed. This happens at the same edge as R3.
- R10: `rst_n` does not change `lat_min`, `lat_max`, `stats_valid` or `lat_var`. Only `stats_clr_n` clears them.
- R11: `lat_var` is 1 exactly when `stats_valid` is 1 and `lat_max`−`lat_min` exceeds VAR_TOL, which defaults to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Asynchronous active-low reset of the measurement |
| stats_clr_n | input | 1 | Asynchronous active-low clear of the min/max statistics |
| sync_n | input | 1 | Receiver SYNC request, active low |
| data_vld | input | 1 | Receive-data-valid indication |
| lat_count | output | CNT_W | Latched latency in link clock cycles |
| lat_done | output | 1 | A result, finished or overflowed, is being held |
| lat_ovf | output | 1 | The held result saturated |
| lat_min | output | CNT_W | Smallest completed result since the last clear |
| lat_max | output | CNT_W | Largest completed result since the last clear |
| stats_valid | output | 1 | At least one result has entered the statistics |
| lat_var | output | 1 | The spread between results exceeds the tolerance |

## Verification
An off-by-one in the counter start, or an edge detector sampling the wrong stage, shifts `lat_count` by one cycle at the R3 edge. A per-cycle reference comparison exposes that on the very first measurement. A controller stuck in the wrong state shows one cycle after the event it mishandles. An abort that does not return to waiting, or a held result that is not frozen, shows as `lat_done` or the statistics moving when valid toggles. Statistics that wrongly obey `rst_n` or skip an update show as a wrong `lat_min`, `lat_max` or `lat_var` on the next result.

// File: rtl/lnklat_pkg.sv
`timescale 1ns/1ps
package lnklat_pkg;

    // Measurement controller states
    typedef enum logic [1:0] {
        ST_WAIT_REL  = 2'd0,
        ST_COUNTING  = 2'd1,
        ST_HELD      = 2'd2,
        ST_SATURATED = 2'd3
    } lat_state_e;

    // Bit positions inside the registered input vector
    localparam int SIG_SYNC = 0;
    localparam int SIG_VLD  = 1;
    localparam int SIG_NUM  = 2;

endpackage

// File: rtl/lnklat_edge.sv
`timescale 1ns/1ps
module lnklat_edge
    import lnklat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_n,
    input  logic data_vld,
    output logic sync_hi,
    output logic sync_rise,
    output logic vld_rise
);

    logic [SIG_NUM-1:0] din;
    logic [SIG_NUM-1:0] stg1_q;
    logic [SIG_NUM-1:0] stg2_q;
    logic [SIG_NUM-1:0] rise;

    assign din[SIG_SYNC] = sync_n;
    assign din[SIG_VLD]  = data_vld;

    // One sampling pipeline per observed input
    for (genvar i = 0; i < SIG_NUM; i++) begin : g_pipe
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg1_q[i] <= 1'b0;
                stg2_q[i] <= 1'b0;
            end else begin
                stg1_q[i] <= din[i];
                stg2_q[i] <= stg1_q[i];
            end
        end
        assign rise[i] = stg1_q[i] & ~stg2_q[i];
    end

    assign sync_hi   = stg1_q[SIG_SYNC];
    assign sync_rise = rise[SIG_SYNC];
    assign vld_rise  = rise[SIG_VLD];

endmodule

// File: rtl/lnklat_fsm.sv
`timescale 1ns/1ps
module lnklat_fsm
    import lnklat_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_hi,
    input  logic             sync_rise,
    input  logic             vld_rise,
    output logic [CNT_W-1:0] lat_count,
    output logic             lat_done,
    output logic             lat_ovf,
    output logic             meas_fire,
    output logic [CNT_W-1:0] meas_val
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    lat_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] lat_q, lat_d;

    // Next-state and datapath decisions
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        lat_d     = lat_q;
        meas_fire = 1'b0;
        unique case (state_q)
            ST_WAIT_REL, ST_HELD, ST_SATURATED: begin
                if (sync_rise) begin
                    lat_d = '0;
                    if (vld_rise) begin
                        state_d   = ST_HELD;      // INSTANT
                        meas_fire = 1'b1;
                    end else begin
                        state_d = ST_COUNTING;    // START
                        cnt_d   = CNT_ONE;
                    end
                end
            end
            ST_COUNTING: begin
                if (!sync_hi) begin
                    state_d = ST_WAIT_REL;        // ABORT
                end else if (vld_rise) begin
                    state_d   = ST_HELD;          // FINISH
                    lat_d     = cnt_q;
                    meas_fire = 1'b1;
                end else if (cnt_q == CNT_MAX) begin
                    state_d = ST_SATURATED;       // OVERFLOW
                    lat_d   = CNT_MAX;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_REL;
        end else begin
            state_q <= state_d;
        end
    end

    // Counter and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lat_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            lat_q <= lat_d;
        end
    end

    // Outputs
    always_comb begin
        lat_count = lat_q;
        meas_val  = lat_d;
        lat_done  = (state_q == ST_HELD) || (state_q == ST_SATURATED);
        lat_ovf   = (state_q == ST_SATURATED);
    end

endmodule

// File: rtl/lnklat_stats.sv
`timescale 1ns/1ps
module lnklat_stats #(
    parameter int CNT_W   = 8,
    parameter int VAR_TOL = 1
) (
    input  logic             clk,
    input  logic             stats_clr_n,
    input  logic             meas_fire,
    input  logic [CNT_W-1:0] meas_val,
    output logic [CNT_W-1:0] lat_min,
    output logic [CNT_W-1:0] lat_max,
    output logic             stats_valid,
    output logic             lat_var
);

    localparam logic [CNT_W-1:0] TOL = CNT_W'(VAR_TOL);

    logic [CNT_W-1:0] min_q, max_q;
    logic             have_q;
    logic [CNT_W-1:0] spread;

    always_ff @(posedge clk or negedge stats_clr_n) begin
        if (!stats_clr_n) begin
            min_q  <= '0;
            max_q  <= '0;
            have_q <= 1'b0;
        end else if (meas_fire) begin
            have_q <= 1'b1;
            if (!have_q || meas_val < min_q) min_q <= meas_val;
            if (!have_q || meas_val > max_q) max_q <= meas_val;
        end
    end

    always_comb begin
        spread      = max_q - min_q;
        lat_min     = min_q;
        lat_max     = max_q;
        stats_valid = have_q;
        lat_var     = have_q && (spread > TOL);
    end

endmodule

// File: rtl/lnklat_meter.sv
`timescale 1ns/1ps
module lnklat_meter #(
    parameter int CNT_W   = 8,
    parameter int VAR_TOL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stats_clr_n,
    input  logic             sync_n,
    input  logic             data_vld,
    output logic [CNT_W-1:0] lat_count,
    output logic             lat_done,
    output logic             lat_ovf,
    output logic [CNT_W-1:0] lat_min,
    output logic [CNT_W-1:0] lat_max,
    output logic             stats_valid,
    output logic             lat_var
);

    logic             sync_hi, sync_rise, vld_rise;
    logic             meas_fire;
    logic [CNT_W-1:0] meas_val;

    lnklat_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_n    (sync_n),
        .data_vld  (data_vld),
        .sync_hi   (sync_hi),
        .sync_rise (sync_rise),
        .vld_rise  (vld_rise)
    );

    lnklat_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_hi   (sync_hi),
        .sync_rise (sync_rise),
        .vld_rise  (vld_rise),
        .lat_count (lat_count),
        .lat_done  (lat_done),
        .lat_ovf   (lat_ovf),
        .meas_fire (meas_fire),
        .meas_val  (meas_val)
    );

    lnklat_stats #(.CNT_W(CNT_W), .VAR_TOL(VAR_TOL)) u_stats (
        .clk         (clk),
        .stats_clr_n (stats_clr_n),
        .meas_fire   (meas_fire),
        .meas_val    (meas_val),
        .lat_min     (lat_min),
        .lat_max     (lat_max),
        .stats_valid (stats_valid),
        .lat_var     (lat_var)
    );

endmodule

// File: rtl/lnklat_meter_chk.sv
`timescale 1ns/1ps
module lnklat_meter_chk #(
    parameter int CNT_W   = 8,
    parameter int VAR_TOL = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stats_clr_n,
    input logic [CNT_W-1:0] lat_count,
    input logic             lat_done,
    input logic             lat_ovf,
    input logic [CNT_W-1:0] lat_min,
    input logic [CNT_W-1:0] lat_max,
    input logic             stats_valid,
    input logic             lat_var
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lat_ovf |-> (lat_done && lat_count == CNT_MAX));

    assert_result_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_done && $past(lat_done) && lat_count != '0) |-> $stable(lat_count));

    assert_min_le_max_R9: assert property (@(posedge clk) disable iff (!stats_clr_n)
        stats_valid |-> (lat_min <= lat_max));

    assert_min_never_up_R9: assert property (@(posedge clk) disable iff (!stats_clr_n)
        (stats_valid && $past(stats_valid)) |-> (lat_min <= $past(lat_min)));

    assert_max_never_down_R9: assert property (@(posedge clk) disable iff (!stats_clr_n)
        (stats_valid && $past(stats_valid)) |-> (lat_max >= $past(lat_max)));

    assert_result_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n || !stats_clr_n)
        ($rose(lat_done) && !lat_ovf) |-> (stats_valid && lat_min <= lat_count && lat_count <= lat_max));

    assert_var_quiet_R11: assert property (@(posedge clk) disable iff (!stats_clr_n)
        (!stats_valid || lat_min == lat_max) |-> !lat_var);

endmodule

bind lnklat_meter lnklat_meter_chk #(.CNT_W(CNT_W), .VAR_TOL(VAR_TOL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stats_clr_n (stats_clr_n),
    .lat_count   (lat_count),
    .lat_done    (lat_done),
    .lat_ovf     (lat_ovf),
    .lat_min     (lat_min),
    .lat_max     (lat_max),
    .stats_valid (stats_valid),
    .lat_var     (lat_var)
);

// File: tb/lnklat_meter_bench.sv
`timescale 1ns/1ps
module lnklat_meter_bench;

    localparam int CW   = 8;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0, stats_clr_n = 1'b0, sync_n = 1'b0, data_vld = 1'b0;
    logic [CW-1:0] lat_count, lat_min, lat_max;
    logic          lat_done, lat_ovf, stats_valid, lat_var;

    lnklat_meter #(.CNT_W(CW), .VAR_TOL(1)) u_lnklat_meter (
        .clk(clk), .rst_n(rst_n), .stats_clr_n(stats_clr_n), .sync_n(sync_n),
        .data_vld(data_vld), .lat_count(lat_count), .lat_done(lat_done),
        .lat_ovf(lat_ovf), .lat_min(lat_min), .lat_max(lat_max),
        .stats_valid(stats_valid), .lat_var(lat_var)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 waiting, 1 counting, 2 held, 3 saturated
    bit m_s1, m_s2, m_v1, m_v2;
    int m_mode = 0, m_start = 0, m_edge = 0, m_lat = 0;
    bit m_have = 0;
    int m_min = 0, m_max = 0;
    bit rel, vr;

    task automatic record(input int v);
        if (stats_clr_n) begin
            if (!m_have || v < m_min) m_min = v;
            if (!m_have || v > m_max) m_max = v;
            m_have = 1;
        end
    endtask

    always @(posedge clk) begin
        m_edge++;
        if (!stats_clr_n) begin
            m_have = 0; m_min = 0; m_max = 0;
        end
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_v1 = 0; m_v2 = 0; m_mode = 0; m_lat = 0;
        end else begin
            rel = m_s1 && !m_s2;
            vr  = m_v1 && !m_v2;
            if (m_mode == 1) begin
                if (!m_s1) m_mode = 0;
                else if (vr) begin
                    m_lat = m_edge - 1 - m_start; m_mode = 2; record(m_lat);
                end else if (m_edge - 1 - m_start == MAXC) begin
                    m_mode = 3; m_lat = MAXC;
                end
            end else if (rel) begin
                m_lat = 0;
                if (vr) begin m_mode = 2; record(0); end
                else begin m_mode = 1; m_start = m_edge - 1; end
            end
            m_s2 = m_s1; m_s1 = sync_n; m_v2 = m_v1; m_v1 = data_vld;
        end
    end

    // Per-cycle comparison against the reference
    always @(posedge clk) begin
        #1;
        chk(int'(lat_count) == m_lat, "R3", "lat_count", int'(lat_count), m_lat);
        chk(lat_done == (m_mode >= 2), "R5", "lat_done", int'(lat_done), int'(m_mode >= 2));
        chk(lat_ovf == (m_mode == 3), "R7", "lat_ovf", int'(lat_ovf), int'(m_mode == 3));
        chk(stats_valid == m_have, "R9", "stats_valid", int'(stats_valid), int'(m_have));
        chk(int'(lat_min) == m_min, "R9", "lat_min", int'(lat_min), m_min);
        chk(int'(lat_max) == m_max, "R9", "lat_max", int'(lat_max), m_max);
        chk(lat_var == (m_have && (m_max - m_min > 1)), "R11", "lat_var",
            int'(lat_var), int'(m_have && (m_max - m_min > 1)));
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int d);
        sync_n = 1'b0; data_vld = 1'b0;
        tick(3);
        sync_n = 1'b1;
        if (d > 0) tick(d);
        data_vld = 1'b1;
        tick(4);
    endtask

    task automatic check_stats(input string req, input int mn, input int mx, input bit vr_exp);
        chk(stats_valid == 1'b1, req, "stats_valid", int'(stats_valid), 1);
        chk(int'(lat_min) == mn, req, "lat_min", int'(lat_min), mn);
        chk(int'(lat_max) == mx, req, "lat_max", int'(lat_max), mx);
        chk(lat_var == vr_exp, req, "lat_var", int'(lat_var), int'(vr_exp));
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(3);
        // R1: reset state
        chk(lat_done == 0 && lat_ovf == 0 && lat_count == 0, "R1", "meas reset", int'(lat_done), 0);
        chk(stats_valid == 0 && lat_var == 0 && lat_min == 0 && lat_max == 0, "R1", "stats reset",
            int'(stats_valid), 0);
        rst_n = 1'b1; stats_clr_n = 1'b1;
        tick(2);

        // R2, R3: basic measurement
        sync_n = 1'b0; tick(3); sync_n = 1'b1; tick(3);
        chk(lat_done == 0, "R2", "done while counting", int'(lat_done), 0);
        tick(7); data_vld = 1'b1; tick(4);
        chk(int'(lat_count) == 10 && lat_done, "R3", "latency 10", int'(lat_count), 10);
        check_stats("R9", 10, 10, 0);

        // R5: valid toggles after the result are ignored
        data_vld = 1'b0; tick(3); data_vld = 1'b1; tick(3); data_vld = 1'b0; tick(3);
        chk(int'(lat_count) == 10 && lat_done, "R5", "held count", int'(lat_count), 10);
        check_stats("R5", 10, 10, 0);

        // R10: reset keeps statistics
        rst_n = 1'b0; tick(2);
        chk(lat_done == 0 && lat_count == 0, "R1", "meas reset again", int'(lat_count), 0);
        check_stats("R10", 10, 10, 0);
        rst_n = 1'b1; tick(2);

        measure(11);
        chk(int'(lat_count) == 11, "R8", "latency 11", int'(lat_count), 11);
        check_stats("R9", 10, 11, 0);

        measure(12);
        chk(int'(lat_count) == 12, "R8", "latency 12", int'(lat_count), 12);
        check_stats("R11", 10, 12, 1);

        // R6: abort by SYNC reassertion
        sync_n = 1'b0; data_vld = 1'b0; tick(3); sync_n = 1'b1; tick(5);
        chk(lat_done == 0 && lat_count == 0, "R2", "release clears result", int'(lat_count), 0);
        sync_n = 1'b0; tick(3); data_vld = 1'b1; tick(4);
        chk(lat_done == 0, "R6", "done after abort", int'(lat_done), 0);
        check_stats("R6", 10, 12, 1);

        measure(9);
        chk(int'(lat_count) == 9, "R8", "latency 9", int'(lat_count), 9);
        check_stats("R9", 9, 12, 1);

        // R4: valid rises with the release
        measure(0);
        chk(int'(lat_count) == 0 && lat_done, "R4", "zero latency", int'(lat_count), 0);
        check_stats("R4", 0, 12, 1);

        // R7: no valid, saturate
        sync_n = 1'b0; data_vld = 1'b0; tick(3); sync_n = 1'b1; tick(270);
        chk(lat_ovf == 1 && lat_done == 1, "R7", "overflow flag", int'(lat_ovf), 1);
        chk(int'(lat_count) == MAXC, "R7", "saturated count", int'(lat_count), MAXC);
        check_stats("R7", 0, 12, 1);
        data_vld = 1'b1; tick(4);
        chk(int'(lat_count) == MAXC && lat_ovf, "R5", "valid after overflow", int'(lat_count), MAXC);

        // R10: dedicated clear, then fresh statistics
        stats_clr_n = 1'b0; tick(2);
        chk(stats_valid == 0 && lat_var == 0 && lat_min == 0 && lat_max == 0, "R10", "stats cleared",
            int'(stats_valid), 0);
        stats_clr_n = 1'b1; tick(1);
        measure(5);
        chk(int'(lat_count) == 5 && !lat_ovf, "R8", "latency 5", int'(lat_count), 5);
        check_stats("R9", 5, 5, 0);

        tick(3);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule